// File: doc/BRIEF.md
# Double-Data-Rate Read Capture with Per-Lane Clock Crossing

This block takes read data coming back from a double-data-rate memory and turns it into wide, aligned words in the controller clock domain. The data bus is split into independent 8-bit byte lanes. Each lane arrives with its own forwarded strobe and one mask bit. The strobes are already phase-shifted and are used directly as capture clocks. On a strobe rising edge a lane latches its even byte. On the falling edge it latches the odd byte and commits the even/odd pair, with both mask bits, to a small asynchronous FIFO owned by that lane.

On the controller side the lane FIFOs are drained together. One wide word is assembled only when every lane holds at least one pair, so bytes that belong to the same transfer leave the block in the same beat. The word is registered and presented with a single-cycle valid flag. A lane that receives a strobe beat while its FIFO is full drops that beat. It raises a sticky overflow flag, which is brought into the controller domain.

Top module: `ddr_rdcap`

## Requirements
- R1: While `rst_n` is low, and until the first word after release, `rd_valid_o` is 0, `rd_data_o` is all zeros and `ovf_o` is all zeros.
- R2: For lane l, the byte on the lane's data pins at the strobe's rising edge appears in `rd_data_o[16*l+7 : 16*l]`. The byte present at the following falling edge appears in `rd_data_o[16*l+15 : 16*l+8]`.
- R3: For lane l, the mask bit sampled at the rising edge appears in `rd_mask_o[2*l]`, and the one sampled at the falling edge appears in `rd_mask_o[2*l+1]`. Mask values are carried through and do not alter the data.
- R4: Lane l occupies bits `16*l` to `16*l+15` of the merged word. A transfer that reaches all lanes yields exactly one word per strobe cycle, with every lane's pair from that cycle.
- R5: No word is produced while any lane FIFO is empty. Beats that reach only some lanes wait, without output, until each remaining lane has received a beat.
- R6: Each lane keeps its pairs in arrival order and can hold 8 of them. The n-th word carries the n-th stored pair of every lane.
- R7: A beat arriving at a lane whose FIFO already holds 8 unread pairs is discarded. The stored pairs stay intact. That lane's bit in `ovf_o` goes to 1 and stays there until reset.
- R8: `rd_data_o` and `rd_mask_o` hold their value in every cycle in which `rd_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dqs_i | input | LANES | Per-lane capture strobe, already phase-shifted |
| dq_i | input | 8*LANES | Per-lane read data byte, lane l at bits 8*l+7:8*l |
| dm_i | input | LANES | Per-lane data mask bit |
| rd_data_o | output | 16*LANES | Merged word: lane l even byte low, odd byte high |
| rd_mask_o | output | 2*LANES | Merged mask: lane l even bit at 2*l, odd bit at 2*l+1 |
| rd_valid_o | output | 1 | One-cycle flag for a new merged word |
| ovf_o | output | LANES | Sticky per-lane overflow flag, controller domain |

## Verification
A swapped edge or a wrong lane slot shows up at once as wrong bytes in the first merged word after the transfer. A corrupted pointer or a wrong empty decision shows up as a missing, duplicated or early word. This appears within a few controller cycles of the beats settling through the two-stage synchronizers. A wrong full decision shows up two ways: a lane's overflow flag is set on the ninth unread beat or is missed there, or one of the eight kept pairs is altered. Both become visible once the other lanes are filled and the stored pairs drain.

// File: rtl/ddr_rdcap_pkg.sv
package ddr_rdcap_pkg;
  localparam int BYTE_W = 8;

  // One strobe cycle of a single lane: odd (falling) and even (rising) halves
  typedef struct packed {
    logic              odd_m;
    logic              even_m;
    logic [BYTE_W-1:0] odd;
    logic [BYTE_W-1:0] even;
  } beat_t;
endpackage

// File: rtl/rdcap_sync.sv
module rdcap_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/rdcap_lane.sv
module rdcap_lane
  import ddr_rdcap_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  // strobe domain
  input  logic              dqs,
  input  logic [BYTE_W-1:0] dq,
  input  logic              dm,
  input  logic              srst_n,
  // controller domain
  input  logic              clk,
  input  logic              crst_n,
  input  logic              pop,
  output beat_t             head,
  output logic              empty,
  output logic              ovf,
  output logic [PW-1:0]     rgray_o
);
  logic              dqs_n;
  logic [BYTE_W-1:0] even_q;
  logic              even_m_q;

  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d, rsync;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d, wsync;
  logic          full, wr_en, rd_en;
  logic          ovf_s_q, ovf_s_d;

  beat_t mem [DEPTH];

  assign dqs_n = ~dqs;

  // ---------------- strobe domain: rising half ----------------
  always_ff @(posedge dqs or negedge srst_n) begin
    if (!srst_n) begin
      even_q   <= '0;
      even_m_q <= 1'b0;
    end else begin
      even_q   <= dq;
      even_m_q <= dm;
    end
  end

  // ---------------- strobe domain: falling half, write side ----------------
  assign full = (wgray_q == {~rsync[PW-1:PW-2], rsync[PW-3:0]});

  always_comb begin
    wr_en   = !full;
    wbin_d  = wbin_q + {{(PW-1){1'b0}}, wr_en};
    wgray_d = wbin_d ^ (wbin_d >> 1);
    ovf_s_d = ovf_s_q | full;
  end

  always_ff @(posedge dqs_n or negedge srst_n) begin
    if (!srst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_s_q <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      ovf_s_q <= ovf_s_d;
    end
  end

  always_ff @(posedge dqs_n) begin
    if (wr_en) begin
      mem[wbin_q[AW-1:0]] <= {dm, even_m_q, dq, even_q};
    end
  end

  rdcap_sync #(.W(PW)) u_rsync (
    .clk   (dqs_n),
    .rst_n (srst_n),
    .d     (rgray_q),
    .q     (rsync)
  );

  // ---------------- controller domain: read side ----------------
  rdcap_sync #(.W(PW)) u_wsync (
    .clk   (clk),
    .rst_n (crst_n),
    .d     (wgray_q),
    .q     (wsync)
  );

  assign empty = (rgray_q == wsync);

  always_comb begin
    rd_en   = pop && !empty;
    rbin_d  = rbin_q + {{(PW-1){1'b0}}, rd_en};
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge clk or negedge crst_n) begin
    if (!crst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  assign head    = mem[rbin_q[AW-1:0]];
  assign rgray_o = rgray_q;

  rdcap_sync #(.W(1)) u_osync (
    .clk   (clk),
    .rst_n (crst_n),
    .d     (ovf_s_q),
    .q     (ovf)
  );
endmodule

// File: rtl/ddr_rdcap.sv
module ddr_rdcap
  import ddr_rdcap_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LANES-1:0]          dqs_i,
  input  logic [LANES*BYTE_W-1:0]   dq_i,
  input  logic [LANES-1:0]          dm_i,
  output logic [LANES*2*BYTE_W-1:0] rd_data_o,
  output logic [LANES*2-1:0]        rd_mask_o,
  output logic                      rd_valid_o,
  output logic [LANES-1:0]          ovf_o
);
  localparam int PW     = $clog2(DEPTH) + 1;
  localparam int SLOT_W = 2 * BYTE_W;
  localparam int WORD_W = LANES * SLOT_W;

  logic [1:0]          rs_q;
  logic                crst_n;
  beat_t               head [LANES];
  logic [LANES-1:0]    empty;
  logic [LANES*PW-1:0] rgray_all;
  logic                take;
  logic [WORD_W-1:0]   data_d, data_q;
  logic [LANES*2-1:0]  mask_d, mask_q;
  logic                valid_q;

  // reset: asserted at once, released on the second controller edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign crst_n = rs_q[1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rdcap_lane #(.DEPTH(DEPTH)) u_lane (
      .dqs     (dqs_i[g]),
      .dq      (dq_i[g*BYTE_W +: BYTE_W]),
      .dm      (dm_i[g]),
      .srst_n  (rst_n),
      .clk     (clk),
      .crst_n  (crst_n),
      .pop     (take),
      .head    (head[g]),
      .empty   (empty[g]),
      .ovf     (ovf_o[g]),
      .rgray_o (rgray_all[g*PW +: PW])
    );
  end

  always_comb begin
    take = ~|empty;
    for (int l = 0; l < LANES; l++) begin
      data_d[l*SLOT_W +: SLOT_W] = {head[l].odd, head[l].even};
      mask_d[l*2 +: 2]           = {head[l].odd_m, head[l].even_m};
    end
  end

  always_ff @(posedge clk or negedge crst_n) begin
    if (!crst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      mask_q  <= '0;
    end else begin
      valid_q <= take;
      if (take) begin
        data_q <= data_d;
        mask_q <= mask_d;
      end
    end
  end

  assign rd_data_o  = data_q;
  assign rd_mask_o  = mask_q;
  assign rd_valid_o = valid_q;
endmodule

// File: rtl/ddr_rdcap_chk.sv
module ddr_rdcap_chk #(
  parameter int LANES = 4,
  parameter int PW    = 4,
  parameter int WW    = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rd_valid,
  input logic [WW-1:0]       rd_data,
  input logic [LANES*2-1:0]  rd_mask,
  input logic [LANES-1:0]    ovf,
  input logic [LANES*PW-1:0] rgray_all
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!rd_valid && ovf == '0));

  // R7
  no_ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ovf & $past(ovf)) == '0));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> ($stable(rd_data) && $stable(rd_mask)));

  for (genvar g = 0; g < LANES; g++) begin : g_ptr
    // R6
    gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rgray_all[g*PW +: PW] ^ $past(rgray_all[g*PW +: PW])) <= 1);
  end
endmodule

bind ddr_rdcap ddr_rdcap_chk #(.LANES(LANES), .PW(PW), .WW(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_valid  (rd_valid_o),
  .rd_data   (rd_data_o),
  .rd_mask   (rd_mask_o),
  .ovf       (ovf_o),
  .rgray_all (rgray_all)
);

// File: tb/test_ddr_rdcap.sv
`timescale 1ns/1ps
module test_ddr_rdcap;
  localparam int LN = 4;

  logic          clk;
  logic          rst_n;
  logic [LN-1:0] dqs;
  logic [LN*8-1:0] dq;
  logic [LN-1:0] dm;
  logic [LN*16-1:0] rd_data;
  logic [LN*2-1:0]  rd_mask;
  logic          rd_valid;
  logic [LN-1:0] ovf;

  ddr_rdcap #(.LANES(LN), .DEPTH(8)) i_ddr_rdcap (
    .clk(clk), .rst_n(rst_n), .dqs_i(dqs), .dq_i(dq), .dm_i(dm),
    .rd_data_o(rd_data), .rd_mask_o(rd_mask), .rd_valid_o(rd_valid), .ovf_o(ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  // reference model
  logic [17:0]      lq [LN][$];
  logic [LN*16-1:0] exp_d [$];
  logic [LN*2-1:0]  exp_m [$];
  logic [LN-1:0]    exp_ovf;
  logic [LN*16-1:0] prev_d;
  logic [LN*2-1:0]  prev_m;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  task automatic model_clear();
    for (int l = 0; l < LN; l++) lq[l].delete();
    exp_d.delete();
    exp_m.delete();
    exp_ovf = '0;
  endtask

  task automatic model_push(input int l, input logic [17:0] b);
    bit all;
    logic [LN*16-1:0] w;
    logic [LN*2-1:0]  m;
    logic [17:0]      f;
    if (lq[l].size() < 8) lq[l].push_back(b);
    else exp_ovf[l] = 1'b1;
    all = 1'b1;
    for (int k = 0; k < LN; k++) if (lq[k].size() == 0) all = 1'b0;
    if (all) begin
      for (int k = 0; k < LN; k++) begin
        f = lq[k].pop_front();
        w[k*16 +: 16] = f[15:0];
        m[k*2 +: 2]   = f[17:16];
      end
      exp_d.push_back(w);
      exp_m.push_back(m);
    end
  endtask

  // one strobe cycle on the lanes selected by en
  task automatic beat(input logic [LN-1:0] en, input logic [31:0] ev, input logic [31:0] od,
                      input logic [LN-1:0] evm, input logic [LN-1:0] odm);
    dq = ev; dm = evm;
    #1 dqs = en;
    #1 dq = od; dm = odm;
    #1 dqs = '0;
    #1;
    for (int l = 0; l < LN; l++)
      if (en[l]) model_push(l, {odm[l], evm[l], od[l*8 +: 8], ev[l*8 +: 8]});
  endtask

  task automatic burst(input logic [LN-1:0] en, input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      logic [31:0] ev, od;
      for (int l = 0; l < LN; l++) begin
        ev[l*8 +: 8] = 8'(seed + k*37 + l*11);
        od[l*8 +: 8] = 8'(~(seed + k*53 + l*7));
      end
      beat(en, ev, od, 4'(seed + k), 4'(~(seed * 3 + k)));
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        if (exp_d.size() == 0) begin
          chk(1'b0, "R5 unexpected word", rd_data, 64'h0);
        end else begin
          logic [LN*16-1:0] ed;
          logic [LN*2-1:0]  em;
          ed = exp_d.pop_front();
          em = exp_m.pop_front();
          chk(rd_data == ed, "R2/R4/R6 data", rd_data, ed);
          chk(rd_mask == em, "R3 mask", 64'(rd_mask), 64'(em));
        end
      end else begin
        chk(rd_data == prev_d && rd_mask == prev_m, "R8 hold", rd_data, prev_d);
      end
    end
    prev_d = rd_data;
    prev_m = rd_mask;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 50000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic reset_and_check();
    rst_n = 1'b0;
    model_clear();
    idle(3);
    @(negedge clk);
    // R1
    chk(rd_valid == 1'b0, "R1 valid", 64'(rd_valid), 64'h0);
    chk(rd_data == '0, "R1 data", rd_data, 64'h0);
    chk(ovf == '0, "R1 ovf", 64'(ovf), 64'h0);
    rst_n = 1'b1;
    idle(4);
    @(negedge clk);
    chk(rd_valid == 1'b0 && ovf == '0, "R1 after release", 64'({rd_valid, ovf}), 64'h0);
  endtask

  initial begin
    rst_n = 1'b0; dqs = '0; dq = '0; dm = '0;
    model_clear();
    prev_d = '0; prev_m = '0;
    reset_and_check();

    // R7: nine beats into lane 0 only; eighth fills it, ninth is dropped
    burst(4'b0001, 9, 8'h21);
    idle(20);
    @(negedge clk);
    chk(ovf == exp_ovf, "R7 flag set", 64'(ovf), 64'(exp_ovf));
    // R5: lane 0 alone produced nothing
    chk(exp_d.size() == 0, "R5 no word from one lane", 64'(exp_d.size()), 64'h0);
    // fill the other lanes: the eight kept lane-0 pairs must drain unaltered (R6, R7)
    burst(4'b1110, 8, 8'h90);
    idle(30);
    @(negedge clk);
    chk(exp_d.size() == 0, "R6 eight words delivered", 64'(exp_d.size()), 64'h0);
    chk(ovf == exp_ovf, "R7 flag sticky", 64'(ovf), 64'(exp_ovf));

    reset_and_check();

    // R2/R3/R4: bursts of one to four strobe cycles on all lanes
    for (int n = 1; n <= 4; n++) begin
      burst(4'b1111, n, 8'h10 * n + 3);
      idle(20);
      @(negedge clk);
      chk(exp_d.size() == 0, "R4 words delivered", 64'(exp_d.size()), 64'h0);
    end

    // R2: distinctive even/odd values per lane
    beat(4'b1111, 32'h44332211, 32'hDDCCBBAA, 4'b0101, 4'b1010);
    beat(4'b1111, 32'h00FF00FF, 32'hFF00FF00, 4'b1111, 4'b0000);
    idle(20);
    @(negedge clk);
    chk(exp_d.size() == 0, "R2 pattern words", 64'(exp_d.size()), 64'h0);

    // R5: partial arrival waits for the last lane
    burst(4'b0111, 2, 8'h5A);
    idle(20);
    @(negedge clk);
    chk(exp_d.size() == 0 && rd_valid == 1'b0, "R5 partial holds", 64'(rd_valid), 64'h0);
    burst(4'b1000, 2, 8'hC3);
    idle(20);
    @(negedge clk);
    chk(exp_d.size() == 0, "R5 completed words", 64'(exp_d.size()), 64'h0);
    chk(ovf == '0, "R7 no false overflow", 64'(ovf), 64'h0);

    summary();
    $finish;
  end
endmodule